// File: doc/BRIEF.md
# Push-Button Hex Counter Display

This block keeps a 24-bit count and shows it as six hexadecimal digits on seven-segment displays. It has two active-low push buttons. A press of the step button adds one to the count. The clear button sets the count to zero. The buttons are assumed to be free of bounce already.

Both button inputs are sampled on the system clock through a short synchronizer. A press is found by comparing each sample with the sample from the previous cycle. No button drives a clock, so every register changes on the same clock edge. The clear button is treated as a level, so the count stays at zero for as long as it is held. If a step press and a held clear fall in the same cycle, the step wins that cycle and the clear takes effect on the next one.

Top module: `pb_hex_counter`

## Requirements
- R1: While the synchronous active-high reset is applied, the count is forced to zero. Afterwards all six digits show the pattern for 0, and both buttons are treated as released.
- R2: A button input at logic 1 is released. While both inputs stay at 1, the count does not change.
- R3: One high-to-low transition of the step input raises the count by exactly one. Keeping the input low adds nothing more, and its return to 1 adds nothing.
- R4: While the clear input is at 0 and no step press is detected, the count becomes zero and stays zero on every cycle.
- R5: If a step press is detected in a cycle where clear is also low, that cycle adds one. The following cycle applies the clear if the clear input is still low.
- R6: With the default two synchronizer stages, a step input that goes low before rising edge 0 shows the new count after rising edge 2 and not before it.
- R7: Digit k (k = 0 is least significant) shows count bits [4k+3:4k] on output bits [7k+6:7k]. Within a digit, bit 0 drives segment a and bit 6 drives segment g. A segment is lit when its bit is 0. The usual hex glyphs for 0 to 9 and A, b, C, d, E, F are used.
- R8: A step from the all-ones count wraps to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| btn_step_n | input | 1 | Step button, active low |
| btn_clear_n | input | 1 | Clear button, active low |
| seg_n | output | 42 | Six active-low 7-bit segment patterns, digit 0 in the low bits |

## Verification
The bench first holds the step button for many cycles. A design that counted on level, or on the release edge, would run ahead. It then presses both buttons in the same cycle and samples two consecutive cycles. The first should show the incremented value and the second should show zero, so a design that gave clear priority, or ignored the held clear, shows a different value. The bench also checks the exact latency cycle, which catches a missing or extra synchronizer stage. A narrow 8-bit instance is stepped through every value and past its wrap. This checks every glyph on two digit positions, and it catches a count that saturates or skips.

// File: rtl/pbhc_pkg.sv
package pbhc_pkg;

    localparam int SEG_W = 7;
    localparam int NIB_W = 4;

    // Active-low glyph for one hex nibble; bit 0 = segment a ... bit 6 = g.
    function automatic logic [SEG_W-1:0] nib_to_seg_n(input logic [NIB_W-1:0] nib);
        logic [SEG_W-1:0] lit;
        case (nib)
            4'h0: lit = 7'h3F;
            4'h1: lit = 7'h06;
            4'h2: lit = 7'h5B;
            4'h3: lit = 7'h4F;
            4'h4: lit = 7'h66;
            4'h5: lit = 7'h6D;
            4'h6: lit = 7'h7D;
            4'h7: lit = 7'h07;
            4'h8: lit = 7'h7F;
            4'h9: lit = 7'h6F;
            4'hA: lit = 7'h77;
            4'hB: lit = 7'h7C;
            4'hC: lit = 7'h39;
            4'hD: lit = 7'h5E;
            4'hE: lit = 7'h79;
            default: lit = 7'h71;
        endcase
        return ~lit;
    endfunction

endpackage

// File: rtl/pbhc_sync.sv
module pbhc_sync #(
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    generate
        if (STAGES == 0) begin : g_bypass
            assign q = d;
        end else begin : g_chain
            logic [STAGES-1:0] chain_d, chain_q;

            always_comb begin
                chain_d[0] = d;
                for (int i = 1; i < STAGES; i++) begin
                    chain_d[i] = chain_q[i-1];
                end
            end

            always_ff @(posedge clk) begin
                if (rst) chain_q <= {STAGES{RST_VAL}};
                else     chain_q <= chain_d;
            end

            assign q = chain_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/pbhc_edge.sv
module pbhc_edge (
    input  logic clk,
    input  logic rst,
    input  logic btn_n,
    output logic press,
    output logic held
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = btn_n;
        press  = prev_q & ~btn_n;
        held   = ~btn_n;
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= prev_d;
    end
endmodule

// File: rtl/pbhc_seg_dec.sv
module pbhc_seg_dec #(
    parameter int DIGITS = 6
) (
    input  logic [DIGITS*pbhc_pkg::NIB_W-1:0] value,
    output logic [DIGITS*pbhc_pkg::SEG_W-1:0] seg_n
);
    import pbhc_pkg::*;

    generate
        for (genvar k = 0; k < DIGITS; k++) begin : g_digit
            assign seg_n[k*SEG_W +: SEG_W] = nib_to_seg_n(value[k*NIB_W +: NIB_W]);
        end
    endgenerate
endmodule

// File: rtl/pb_hex_counter.sv
module pb_hex_counter #(
    parameter int CNT_W       = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     btn_step_n,
    input  logic                     btn_clear_n,
    output logic [(CNT_W/4)*7-1:0]   seg_n
);
    import pbhc_pkg::*;

    localparam int DIGITS = CNT_W / NIB_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } state_t;

    state_t st_d, st_q;

    logic step_s, clear_s;
    logic inc_pulse, inc_held;
    logic clr_pulse, clr_lvl;
    logic [CNT_W-1:0] cnt_q;

    pbhc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) step_sync_i (
        .clk(clk), .rst(rst), .d(btn_step_n), .q(step_s)
    );

    pbhc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) clear_sync_i (
        .clk(clk), .rst(rst), .d(btn_clear_n), .q(clear_s)
    );

    pbhc_edge step_edge_i (
        .clk(clk), .rst(rst), .btn_n(step_s), .press(inc_pulse), .held(inc_held)
    );

    pbhc_edge clear_edge_i (
        .clk(clk), .rst(rst), .btn_n(clear_s), .press(clr_pulse), .held(clr_lvl)
    );

    always_comb begin
        st_d = st_q;
        if (inc_pulse)    st_d.cnt = st_q.cnt + 1'b1;
        else if (clr_lvl) st_d.cnt = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign cnt_q = st_q.cnt;

    pbhc_seg_dec #(.DIGITS(DIGITS)) dec_i (
        .value(cnt_q),
        .seg_n(seg_n)
    );

    logic unused_ok;
    assign unused_ok = ^{inc_held, clr_pulse};
endmodule

// File: rtl/pbhc_checker.sv
module pbhc_checker #(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst,
    input logic             inc_pulse,
    input logic             clr_lvl,
    input logic [CNT_W-1:0] cnt_q
);
    // R3 / R5 / R8: a detected press adds exactly one (wrapping), even with clear low
    assert_step_adds_one_R3: assert property (@(posedge clk) disable iff (rst)
        inc_pulse |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

    // R3: a press pulse never lasts two cycles
    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        inc_pulse |=> !inc_pulse);

    // R4: clear level without a press forces zero
    assert_clear_zeroes_R4: assert property (@(posedge clk) disable iff (rst)
        (clr_lvl && !inc_pulse) |=> cnt_q == '0);

    // R2: no press and no clear keeps the count
    assert_idle_holds_R2: assert property (@(posedge clk) disable iff (rst)
        (!clr_lvl && !inc_pulse) |=> $stable(cnt_q));
endmodule

bind pb_hex_counter pbhc_checker #(.CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst(rst), .inc_pulse(inc_pulse), .clr_lvl(clr_lvl), .cnt_q(cnt_q)
);

// File: tb/pb_hex_counter_tb_top.sv
module pb_hex_counter_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic step_n = 1'b1, clear_n = 1'b1;
    logic w_step_n = 1'b1;
    logic [41:0] seg_n;
    logic [13:0] w_seg_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    pb_hex_counter dut_i (
        .clk(clk), .rst(rst), .btn_step_n(step_n), .btn_clear_n(clear_n), .seg_n(seg_n)
    );

    pb_hex_counter #(.CNT_W(8)) wrap_i (
        .clk(clk), .rst(rst), .btn_step_n(w_step_n), .btn_clear_n(1'b1), .seg_n(w_seg_n)
    );

    // Lit-segment glyphs, bit0 = a .. bit6 = g (active high here, inverted below)
    localparam logic [6:0] GLYPH [16] = '{
        7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
        7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71
    };

    // {step, clear, expected count after the action}
    localparam logic [25:0] VECS [8] = '{
        {1'b1, 1'b0, 24'h000001},
        {1'b1, 1'b0, 24'h000002},
        {1'b0, 1'b0, 24'h000002},
        {1'b1, 1'b0, 24'h000003},
        {1'b0, 1'b1, 24'h000000},
        {1'b0, 1'b1, 24'h000000},
        {1'b1, 1'b0, 24'h000001},
        {1'b1, 1'b0, 24'h000002}
    };

    function automatic logic [41:0] exp_seg(input logic [23:0] v, input int digits);
        logic [41:0] r = '0;
        for (int k = 0; k < digits; k++) begin
            r[k*7 +: 7] = ~GLYPH[v[k*4 +: 4]];
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [41:0] act, input logic [41:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic act(input logic s, input logic c);
        @(negedge clk);
        step_n  = ~s;
        clear_n = ~c;
        repeat (4) @(negedge clk);
        step_n  = 1'b1;
        clear_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state shows zero on all digits
        check("R1 reset", seg_n, exp_seg(24'h0, 6));
        check("R1 reset narrow", {28'h0, w_seg_n}, exp_seg(24'h0, 2));

        // Vector table: R2 idle, R3 step, R4 clear, R7 encoding
        foreach (VECS[i]) begin
            act(VECS[i][25], VECS[i][24]);
            check("R3/R4/R2/R7 vector", seg_n, exp_seg(VECS[i][23:0], 6));
        end

        // R6: latency, count is 2 here
        @(negedge clk);
        step_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R6 not before edge 2", seg_n, exp_seg(24'h2, 6));
        @(negedge clk);
        check("R6 at edge 2", seg_n, exp_seg(24'h3, 6));
        // R3: long hold adds nothing more
        repeat (20) @(negedge clk);
        check("R3 held step", seg_n, exp_seg(24'h3, 6));
        step_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R3 release adds nothing", seg_n, exp_seg(24'h3, 6));

        // R5: both pressed together, step wins, clear follows
        step_n  = 1'b0;
        clear_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R5 step priority", seg_n, exp_seg(24'h4, 6));
        @(negedge clk);
        check("R5 clear next cycle", seg_n, exp_seg(24'h0, 6));
        repeat (6) @(negedge clk);
        check("R4 held clear stays zero", seg_n, exp_seg(24'h0, 6));
        step_n  = 1'b1;
        clear_n = 1'b1;
        repeat (4) @(negedge clk);

        // R7: upper digits, 0x11 after 17 steps
        for (int i = 0; i < 17; i++) act(1'b1, 1'b0);
        check("R7 two digits", seg_n, exp_seg(24'h11, 6));

        // R8 / R7: narrow instance through every value and the wrap
        for (int i = 1; i <= 256; i++) begin
            @(negedge clk);
            w_step_n = 1'b0;
            repeat (3) @(negedge clk);
            w_step_n = 1'b1;
            repeat (3) @(negedge clk);
            check(i == 256 ? "R8 wrap" : "R7 glyph sweep",
                  {28'h0, w_seg_n}, exp_seg(24'(i % 256), 2));
        end

        // R1: reset mid-count
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset again", seg_n, exp_seg(24'h0, 6));

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule